// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker with Colour Palette

This block sits between the memory fetch path of a display controller and its timing generator. It takes 32-bit words from the framebuffer over a valid/ready stream and, each time the timing side raises a pixel-request strobe, it delivers one 24-bit RGB pixel. A 2-bit format input picks how the words are read. In indexed mode each byte of a word selects one entry of a 256-entry colour palette. In 16-bit mode each halfword is a 5-6-5 colour that is widened to 8-8-8. In true-colour mode each word holds one pixel.

The palette is loaded through one write port. A single 32-bit write carries the entry number and all three colour channels. Every format has the same output latency, so the timing side can use one fixed delay. When a pixel is requested and no word is buffered, the block returns black and flags an underrun for that pixel.

Top module: `pix_unpack`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `px_valid` and `px_underrun` are low and `word_ready` is high.
- R2: With `fmt` = 1, each word gives four pixels, taken from bits 31:24 first, then 23:16, 15:8 and 7:0. Each byte is the index of the palette entry that is output.
- R3: With `fmt` = 2, each word gives two pixels, taken from bits 31:16 first and then 15:0. Within a halfword, red is bits 15:11, green is 10:5 and blue is 4:0. Each channel is widened to 8 bits by repeating its top bits below it, so 5'h1F becomes 8'hFF and 6'h20 becomes 8'h82.
- R4: With `fmt` = 3, and also with `fmt` = 0, each word gives one pixel. Red is bits 23:16, green 15:8 and blue 7:0. Bits 31:24 have no effect on the output.
- R5: When `pal_we` is high, entry `pal_wdata[31:24]` of the 256-entry palette is loaded with red `pal_wdata[23:16]`, green `pal_wdata[15:8]` and blue `pal_wdata[7:0]`.
- R6: If a palette write and an indexed pixel read hit the same entry in the same cycle, the pixel shows the entry's old contents.
- R7: A pixel requested at a rising clock edge appears on `px_rgb`, with `px_valid` high, after the second rising edge that follows. The latency is the same for every format.
- R8: If `pix_req` is high while no word is buffered, the pixel delivered is 24'h000000 with `px_underrun` high, and no word is consumed.
- R9: `word_ready` is high when no word is buffered, or when the current request takes the last pixel of the buffered word. A word accepted at an edge serves requests from the next cycle on.
- R10: A cycle without `pix_req` produces `px_valid` low two edges later and does not advance the pixel position within the buffered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Pixel format: 1 indexed 8-bit, 2 RGB565, 3 or 0 true colour |
| word_data | input | 32 | Framebuffer word |
| word_valid | input | 1 | `word_data` is offered |
| word_ready | output | 1 | Block takes the offered word at this edge |
| pix_req | input | 1 | Request for one pixel |
| pal_we | input | 1 | Palette write strobe |
| pal_wdata | input | 32 | Packed palette write: index, red, green, blue |
| px_rgb | output | 24 | Output pixel, red in 23:16, green in 15:8, blue in 7:0 |
| px_valid | output | 1 | `px_rgb` holds a requested pixel |
| px_underrun | output | 1 | The delivered pixel is black because of an underrun |

## Verification
The block has no parameters, so the bench builds the one fixed shape: the full 256-entry palette and all three slot counts per word. Every palette entry is loaded and every format runs with both dense and sparse requests, which reaches each byte and halfword slot, the word hand-over on the last slot, and underruns at the end of each burst. A same-cycle write and read of one palette entry, the extreme 5-6-5 codes, and words with a non-zero top byte are also driven.

// File: rtl/pix_unpack.sv
module pix_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt,
  input  logic [31:0] word_data,
  input  logic        word_valid,
  output logic        word_ready,
  input  logic        pix_req,
  input  logic        pal_we,
  input  logic [31:0] pal_wdata,
  output logic [23:0] px_rgb,
  output logic        px_valid,
  output logic        px_underrun
);
  localparam int PAL_N = 256;

  logic [31:0] cur;
  logic        have;
  logic [1:0]  slot;
  logic [1:0]  last_slot;
  logic        last, take;
  logic [31:0] byte_sh, half_sh;
  logic [15:0] hw;
  logic [23:0] direct;

  logic [23:0] pal [PAL_N];
  logic [23:0] pal_q;
  logic        v1, ur1, sel_pal1;
  logic [23:0] rgb1;

  assign last_slot  = (fmt == 2'd1) ? 2'd3 : (fmt == 2'd2) ? 2'd1 : 2'd0;
  assign last       = slot >= last_slot;
  assign take       = pix_req && have;
  assign word_ready = !have || (pix_req && last);

  assign byte_sh = cur << {slot, 3'b000};
  assign half_sh = cur << {slot[0], 4'b0000};
  assign hw      = half_sh[31:16];
  assign direct  = (fmt == 2'd2)
                 ? {hw[15:11], hw[15:13], hw[10:5], hw[10:9], hw[4:0], hw[4:2]}
                 : cur[23:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '0;
      have <= 1'b0;
      slot <= '0;
    end else if (word_valid && word_ready) begin
      cur  <= word_data;
      have <= 1'b1;
      slot <= '0;
    end else if (take) begin
      if (last) have <= 1'b0;
      else      slot <= slot + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (pal_we) pal[pal_wdata[31:24]] <= pal_wdata[23:0];
    if (take)   pal_q <= pal[byte_sh[31:24]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1          <= 1'b0;
      ur1         <= 1'b0;
      sel_pal1    <= 1'b0;
      rgb1        <= '0;
      px_valid    <= 1'b0;
      px_underrun <= 1'b0;
      px_rgb      <= '0;
    end else begin
      v1          <= pix_req;
      ur1         <= pix_req && !have;
      sel_pal1    <= (fmt == 2'd1) && have;
      rgb1        <= have ? direct : 24'h0;
      px_valid    <= v1;
      px_underrun <= ur1;
      px_rgb      <= sel_pal1 ? pal_q : rgb1;
    end
  end
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        word_ready,
  input logic        pix_req,
  input logic [23:0] px_rgb,
  input logic        px_valid,
  input logic        px_underrun
);
  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |-> ##2 px_valid);                                        // R7
  AST_IDLE_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |-> ##2 !px_valid);                                      // R10
  AST_UNDERRUN_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    px_underrun |-> (px_valid && px_rgb == 24'h0));                   // R8
  AST_UNDERRUN_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(px_underrun) |-> $past(pix_req, 2));                        // R8
  AST_HELD_WORD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (!word_ready || pix_req));         // R9
endmodule

bind pix_unpack pix_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
  .pix_req(pix_req), .px_rgb(px_rgb), .px_valid(px_valid), .px_underrun(px_underrun)
);

// File: tb/pix_unpack_bench.sv
module pix_unpack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd1;
  logic [31:0] word_data = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic        pix_req = 1'b0;
  logic        pal_we = 1'b0;
  logic [31:0] pal_wdata = '0;
  logic [23:0] px_rgb;
  logic        px_valid, px_underrun;

  always #5 clk = ~clk;

  pix_unpack u_pix_unpack (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .pix_req(pix_req),
    .pal_we(pal_we), .pal_wdata(pal_wdata), .px_rgb(px_rgb),
    .px_valid(px_valid), .px_underrun(px_underrun)
  );

  int total = 0, fails = 0;
  bit done = 0;

  logic [31:0] q[$];
  logic [23:0] m_pal [256];
  bit          m_have = 0;
  int          m_slot = 0;
  logic [31:0] m_cur = '0;

  bit e_v = 0, e_u = 0, p_v = 0, p_u = 0;
  logic [23:0] e_rgb = '0, p_rgb = '0;
  string e_tag = "R7", p_tag = "R7";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nper(input logic [1:0] f);
    return (f == 2'd1) ? 4 : (f == 2'd2) ? 2 : 1;
  endfunction

  function automatic logic [7:0] widen(input int v, input int bits);
    return 8'((v << (8 - bits)) | (v >> (2 * bits - 8)));
  endfunction

  function automatic logic [23:0] ref_px(input logic [1:0] f, input logic [31:0] w, input int s);
    int h;
    if (f == 2'd1) return m_pal[(w >> (8 * (3 - s))) & 255];
    if (f == 2'd2) begin
      h = int'((w >> (16 * (1 - s))) & 32'hFFFF);
      return {widen(h >> 11, 5), widen((h >> 5) & 63, 6), widen(h & 31, 5)};
    end
    return w[23:0];
  endfunction

  function automatic string ftag(input logic [1:0] f);
    return (f == 2'd1) ? "R2" : (f == 2'd2) ? "R3" : "R4";
  endfunction

  task automatic step(input bit req, input bit src_en, input bit we, input logic [31:0] wd);
    bit m_ready, n_v, n_u, acc;
    logic [23:0] n_rgb;
    string n_tag;
    chk(px_valid == e_v, e_v ? "R7" : "R10", {31'b0, px_valid}, {31'b0, e_v});
    chk(px_underrun == e_u, "R8", {31'b0, px_underrun}, {31'b0, e_u});
    if (e_v) chk(px_rgb == e_rgb, e_tag, {8'b0, px_rgb}, {8'b0, e_rgb});
    pix_req    = req;
    pal_we     = we;
    pal_wdata  = wd;
    word_valid = src_en && (q.size() > 0);
    word_data  = word_valid ? q[0] : '0;
    #1;
    m_ready = !m_have || (req && m_slot == nper(fmt) - 1);
    chk(word_ready == m_ready, "R9", {31'b0, word_ready}, {31'b0, m_ready});
    n_v = req; n_u = req && !m_have; n_rgb = '0; n_tag = "R8";
    if (req && m_have) begin
      n_rgb = ref_px(fmt, m_cur, m_slot);
      n_tag = ftag(fmt);
      if (m_slot == nper(fmt) - 1) m_have = 0;
      else m_slot++;
    end
    if (we) m_pal[wd[31:24]] = wd[23:0];
    acc = word_valid && m_ready;
    if (acc) begin m_cur = q.pop_front(); m_have = 1; m_slot = 0; end
    @(posedge clk);
    e_v = p_v; e_u = p_u; e_rgb = p_rgb; e_tag = p_tag;
    p_v = n_v; p_u = n_u; p_rgb = n_rgb; p_tag = n_tag;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic run_random(input logic [1:0] f, input int words, input int cycles);
    fmt = f;
    for (int i = 0; i < words; i++) q.push_back($urandom);
    for (int i = 0; i < cycles; i++) step(($urandom % 4) != 0, ($urandom % 3) != 0, 1'b0, '0);
    q.delete();
    drain();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(px_valid == 0 && px_underrun == 0, "R1", {30'b0, px_valid, px_underrun}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(px_valid == 0 && px_underrun == 0, "R1", {30'b0, px_valid, px_underrun}, 32'h0);
    chk(word_ready == 1'b1, "R1", {31'b0, word_ready}, 32'h1);

    // R5: load every palette entry
    for (int i = 0; i < 256; i++)
      step(1'b0, 1'b0, 1'b1, {8'(i), 8'(i * 7), 8'(i ^ 8'h5A), 8'(255 - i)});

    // R2: indexed, dense requests, ending in underrun (R8)
    fmt = 2'd1;
    q.push_back(32'h00FF8001); q.push_back(32'h12345678); q.push_back(32'hA5C30F7E);
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b0, '0);
    drain();

    // R6: write and read of entry 8'h10 in the same cycle
    q.push_back(32'h10101010);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 1'b1, 32'h10ABCDEF);
    step(1'b1, 1'b1, 1'b0, '0);
    drain();

    // R3: extreme 565 codes
    fmt = 2'd2;
    q.push_back(32'hFFFF0000); q.push_back(32'h84100841); q.push_back(32'hF81F07E0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, '0);
    drain();

    // R4: top byte ignored, format 3 and 0
    fmt = 2'd3;
    q.push_back(32'hFF123456); q.push_back(32'h00123456); q.push_back(32'h5AFFFFFF);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, '0);
    drain();
    fmt = 2'd0;
    q.push_back(32'hC3ABCDEF); q.push_back(32'h00000001);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, '0);
    drain();

    // R10: gaps between requests keep position
    fmt = 2'd1;
    q.push_back(32'h01020304);
    for (int i = 0; i < 10; i++) step(i % 3 == 0, 1'b1, 1'b0, '0);
    drain();

    // R9, R7: random traffic per format
    run_random(2'd1, 40, 300);
    run_random(2'd2, 40, 300);
    run_random(2'd3, 40, 200);

    done = 1;
    summary();
  end
endmodule